// File: doc/BRIEF.md
# Analog Core Test Wrapper Controller

This block is the digital side of a test wrapper that surrounds an analog core. In bypass mode it is transparent: the functional input is routed straight through to the core input and the converter path stays idle. In the two test modes the core is instead reached through an 8-bit DAC and ADC. A digital test bus feeds stimulus samples in narrow beats, and the block reassembles them into DAC codes. It captures ADC codes at the programmed sampling rate and sends them back out over the bus in the same beat format.

Every test starts from a configuration image. The image holds the sampling divider, the bus width, the sample count and a flag that time-shares the wrapper between two cores. Software may write the image at any time, but it is copied into the working registers only when a test starts. A run of tests is applied back to back: configure, start, wait for done, and repeat. The sample rate must be at least twice the highest test frequency, and the sample count must span at least two periods of the lowest one. The tester chooses the divider and count to meet both rules.

Self-test mode closes the converter loop outside the block. Each ADC code is compared against the DAC code that was being driven when it was taken, and any difference raises a sticky fail flag.

Top module: `atw_ctrl`

## Requirements
- R1: After reset, done_o, fail_o, resp_vld_o, dac_stb_o and core_sel_o are all 0.
- R2: When mode_i is not 1 (test) or 2 (self-test), core_in_o equals func_i, conv_en_o is 0, and start_i causes no DAC strobe and no response beat.
- R3: After start_i in a test mode, dac_stb_o pulses once every div+1 clock cycles, where div is the divider value of the active configuration.
- R4: The stimulus bus carries 1, 2, 4 or 8 bits per beat, selected by wsel = 0, 1, 2 or 3. Each 8-bit sample takes 8/width beats, least significant part first. At each strobe, dac_code_o shows the last complete sample.
- R5: At each sampling instant, adc_code_i is captured and sent on resp_dat_o as 8/width beats, least significant part first. The beats start in the same cycle as dac_stb_o and follow on consecutive cycles, each marked by resp_vld_o.
- R6: A test produces exactly cnt strobes (cnt of at least 1). done_o is then set and the controller is idle. done_o stays set until the next accepted start, which clears it.
- R7: A configuration written while a test is running does not change that test's rate, width, count or sharing. It takes effect at the next start.
- R8: With sharing enabled, core_sel_o takes the values 0, 1, 0, 1 … on successive strobes, so each core gets half the sample rate. With sharing disabled, core_sel_o is 0 on every strobe.
- R9: In self-test, any strobe instant where adc_code_i differs from the code being driven on dac_code_o sets fail_o. fail_o stays set, through later test-mode runs as well, until the next self-test start.
- R10: In test or self-test mode, core_in_o is 0 and conv_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 bypass, 1 test, 2 self-test, 3 bypass |
| func_i | input | 8 | Functional signal for the core |
| core_in_o | output | 8 | Core input in bypass, 0 otherwise |
| conv_en_o | output | 1 | Converter path selected |
| cfg_vld_i | input | 1 | Write configuration image |
| cfg_div_i | input | 12 | Sampling divider (period = div+1) |
| cfg_wsel_i | input | 2 | Bus width code |
| cfg_cnt_i | input | 16 | Samples per test |
| cfg_share_i | input | 1 | Time-share two cores |
| start_i | input | 1 | Start a test when idle |
| stim_vld_i | input | 1 | Stimulus beat valid |
| stim_dat_i | input | 8 | Stimulus beat, low width bits used |
| resp_vld_o | output | 1 | Response beat valid |
| resp_dat_o | output | 8 | Response beat, low width bits |
| dac_code_o | output | 8 | Code to the DAC |
| dac_stb_o | output | 1 | Sampling instant strobe |
| adc_code_i | input | 8 | Code from the ADC |
| core_sel_o | output | 1 | Core served by this sample |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | Sticky self-test mismatch |

## Verification
The assertions take four things for granted about the inputs. The sample count is never zero. mode_i does not change while a test runs. The bus width stays fixed from start until the last response beat has left. Each sampling period has at least one more cycle than the number of beats per sample. The bench keeps within these limits: it changes mode only between tests, waits for the response beats to drain before each new start, and picks divider and width pairs with period ≥ beats + 1. It sends every stimulus sample right after the strobe that consumes the previous one, so no sample completes on the same edge as a sampling instant.

// File: rtl/atw_pkg.sv
// Shared types and helpers for the analog test wrapper controller.
// Assumes the sample width is a multiple of 8 so every width code divides it.
package atw_pkg;
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_TEST   = 2'd1,
        MODE_SELF   = 2'd2
    } atw_mode_e;

    // Bits carried per bus beat for a width code.
    function automatic int bus_bits(input logic [1:0] wsel);
        return 1 << wsel;
    endfunction

    // Beats needed to move one sample for a width code.
    function automatic int beats_per(input int samp_w, input logic [1:0] wsel);
        return samp_w >> wsel;
    endfunction
endpackage

// File: rtl/atw_ticker.sv
// Sampling-instant generator: divides the clock by div_i+1 and counts the
// samples of one test. Assumes div_i and cnt_i stay fixed during a run and
// cnt_i is at least 1.
module atw_ticker #(
    parameter int DIV_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             tick_o,
    output logic             expire_o,
    output logic             run_o
);
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] left_q;
    logic             run_q;

    assign tick_o   = run_q && (div_q == div_i);
    assign expire_o = tick_o && (left_q == CNT_W'(1));
    assign run_o    = run_q;

    // Divider phase and remaining-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
        end else if (go_i) begin
            div_q  <= '0;
            left_q <= cnt_i;
            run_q  <= 1'b1;
        end else if (run_q) begin
            if (tick_o) begin
                div_q  <= '0;
                left_q <= left_q - CNT_W'(1);
                if (expire_o) run_q <= 1'b0;
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (div_q <= div_i));
    assert_left_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (left_q != '0));
endmodule

// File: rtl/atw_unpack.sv
// Stimulus deserialiser: gathers bus beats, least significant part first,
// into full samples and holds the last complete one. Assumes wsel_i only
// changes together with clr_i.
module atw_unpack #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [1:0]        wsel_i,
    input  logic              beat_vld_i,
    input  logic [SAMP_W-1:0] beat_dat_i,
    output logic [SAMP_W-1:0] smp_o
);
    import atw_pkg::*;
    localparam int BC_W = $clog2(SAMP_W + 1);

    logic [SAMP_W-1:0] asm_q, merged, mask;
    logic [BC_W-1:0]   bc_q, last_bc;
    int                bw;

    // Next assembly value with the new beat placed in the top bits.
    always_comb begin
        bw      = bus_bits(wsel_i);
        mask    = SAMP_W'((1 << bw) - 1);
        merged  = (asm_q >> bw) | ((beat_dat_i & mask) << (SAMP_W - bw));
        last_bc = BC_W'(beats_per(SAMP_W, wsel_i) - 1);
    end

    // Beat accumulation and sample hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q <= '0;
            bc_q  <= '0;
            smp_o <= '0;
        end else if (clr_i) begin
            asm_q <= '0;
            bc_q  <= '0;
        end else if (beat_vld_i) begin
            asm_q <= merged;
            if (bc_q == last_bc) begin
                bc_q  <= '0;
                smp_o <= merged;
            end else begin
                bc_q <= bc_q + BC_W'(1);
            end
        end
    end

    assert_beat_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bc_q <= last_bc);
endmodule

// File: rtl/atw_pack.sv
// Response serialiser: on load takes one sample and emits it as bus beats,
// least significant part first, one per cycle. Assumes wsel_i is fixed while
// beats are outstanding.
module atw_pack #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        wsel_i,
    input  logic [SAMP_W-1:0] code_i,
    output logic              beat_vld_o,
    output logic [SAMP_W-1:0] beat_dat_o
);
    import atw_pkg::*;
    localparam int BC_W = $clog2(SAMP_W + 1);

    logic [SAMP_W-1:0] sreg_q, mask;
    logic [BC_W-1:0]   left_q, nbeat;
    int                bw;

    // Width-dependent mask and beat count.
    always_comb begin
        bw    = bus_bits(wsel_i);
        mask  = SAMP_W'((1 << bw) - 1);
        nbeat = BC_W'(beats_per(SAMP_W, wsel_i));
    end

    assign beat_vld_o = (left_q != '0);
    assign beat_dat_o = sreg_q & mask;

    // Shift register advancing one beat per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sreg_q <= code_i;
            left_q <= nbeat;
        end else if (left_q != '0) begin
            sreg_q <= sreg_q >> bw;
            left_q <= left_q - BC_W'(1);
        end
    end

    assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= nbeat);
endmodule

// File: rtl/atw_loopchk.sv
// Self-test comparator: at each checked instant compares the looped-back ADC
// code with the DAC code being driven and latches any mismatch.
module atw_loopchk #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              chk_i,
    input  logic [SAMP_W-1:0] sent_i,
    input  logic [SAMP_W-1:0] got_i,
    output logic              fail_o
);
    // Sticky mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                         fail_o <= 1'b0;
        else if (clr_i)                     fail_o <= 1'b0;
        else if (chk_i && sent_i != got_i)  fail_o <= 1'b1;
    end

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clr_i) |=> fail_o);
endmodule

// File: rtl/atw_ctrl.sv
// Test wrapper controller top: bypass routing, configuration shadowing,
// sampling control, stimulus/response serialisation, self-test compare and
// two-core time sharing. Assumes mode_i is steady during a test.
module atw_ctrl #(
    parameter int SAMP_W = 8,
    parameter int DIV_W  = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [SAMP_W-1:0] func_i,
    output logic [SAMP_W-1:0] core_in_o,
    output logic              conv_en_o,
    input  logic              cfg_vld_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [1:0]        cfg_wsel_i,
    input  logic [CNT_W-1:0]  cfg_cnt_i,
    input  logic              cfg_share_i,
    input  logic              start_i,
    input  logic              stim_vld_i,
    input  logic [SAMP_W-1:0] stim_dat_i,
    output logic              resp_vld_o,
    output logic [SAMP_W-1:0] resp_dat_o,
    output logic [SAMP_W-1:0] dac_code_o,
    output logic              dac_stb_o,
    input  logic [SAMP_W-1:0] adc_code_i,
    output logic              core_sel_o,
    output logic              done_o,
    output logic              fail_o
);
    import atw_pkg::*;

    logic              bypass, go, tick, expire, run;
    logic [DIV_W-1:0]  sh_div, act_div;
    logic [1:0]        sh_wsel, act_wsel;
    logic [CNT_W-1:0]  sh_cnt, act_cnt;
    logic              sh_share, act_share, act_self, slot_q;
    logic [SAMP_W-1:0] smp;

    assign bypass    = !(mode_i == MODE_TEST || mode_i == MODE_SELF);
    assign core_in_o = bypass ? func_i : '0;
    assign conv_en_o = !bypass;
    assign go        = start_i && !run && !bypass;

    // Shadow image written at any time by the tester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div <= '0; sh_wsel <= '0; sh_cnt <= CNT_W'(1); sh_share <= 1'b0;
        end else if (cfg_vld_i) begin
            sh_div <= cfg_div_i; sh_wsel <= cfg_wsel_i;
            sh_cnt <= cfg_cnt_i; sh_share <= cfg_share_i;
        end
    end

    // Working configuration, copied only at a test boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div <= '0; act_wsel <= '0; act_cnt <= CNT_W'(1);
            act_share <= 1'b0; act_self <= 1'b0;
        end else if (go) begin
            act_div <= sh_div; act_wsel <= sh_wsel; act_cnt <= sh_cnt;
            act_share <= sh_share; act_self <= (mode_i == MODE_SELF);
        end
    end

    atw_ticker #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ticker (
        .clk(clk), .rst_n(rst_n), .go_i(go), .div_i(act_div), .cnt_i(sh_cnt),
        .tick_o(tick), .expire_o(expire), .run_o(run)
    );

    atw_unpack #(.SAMP_W(SAMP_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .clr_i(go), .wsel_i(act_wsel),
        .beat_vld_i(stim_vld_i && run), .beat_dat_i(stim_dat_i), .smp_o(smp)
    );

    atw_pack #(.SAMP_W(SAMP_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .load_i(tick), .wsel_i(act_wsel),
        .code_i(adc_code_i), .beat_vld_o(resp_vld_o), .beat_dat_o(resp_dat_o)
    );

    atw_loopchk #(.SAMP_W(SAMP_W)) u_loopchk (
        .clk(clk), .rst_n(rst_n), .clr_i(go && mode_i == MODE_SELF),
        .chk_i(tick && act_self), .sent_i(dac_code_o), .got_i(adc_code_i),
        .fail_o(fail_o)
    );

    // DAC update, core slot rotation and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code_o <= '0; dac_stb_o <= 1'b0; core_sel_o <= 1'b0;
            slot_q <= 1'b0; done_o <= 1'b0;
        end else begin
            dac_stb_o <= tick;
            if (go) begin
                done_o <= 1'b0;
                slot_q <= 1'b0;
            end
            if (tick) begin
                dac_code_o <= smp;
                core_sel_o <= slot_q;
                slot_q     <= act_share ? !slot_q : 1'b0;
            end
            if (expire) done_o <= 1'b1;
        end
    end

    assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !dac_stb_o);
    assert_done_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !run);
    assert_sel_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_sel_o) |-> dac_stb_o);
    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !go) |=> $stable(act_div) && $stable(act_wsel) && $stable(act_share));
endmodule

// File: tb/atw_ctrl_tb.sv
// Scoreboard bench: the driver queues expected DAC codes, the monitor
// derives expected response samples and compares everything it observes.
module atw_ctrl_tb;
    import atw_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cfg_vld, cfg_share, start, stim_vld;
    logic [1:0] mode, cfg_wsel;
    logic [7:0] func, core_in, stim_dat, resp_dat, dac_code, adc_code;
    logic [11:0] cfg_div;
    logic [15:0] cfg_cnt;
    logic conv_en, resp_vld, dac_stb, core_sel, done, fail;

    atw_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .func_i(func), .core_in_o(core_in),
        .conv_en_o(conv_en), .cfg_vld_i(cfg_vld), .cfg_div_i(cfg_div),
        .cfg_wsel_i(cfg_wsel), .cfg_cnt_i(cfg_cnt), .cfg_share_i(cfg_share),
        .start_i(start), .stim_vld_i(stim_vld), .stim_dat_i(stim_dat),
        .resp_vld_o(resp_vld), .resp_dat_o(resp_dat), .dac_code_o(dac_code),
        .dac_stb_o(dac_stb), .adc_code_i(adc_code), .core_sel_o(core_sel),
        .done_o(done), .fail_o(fail)
    );

    int compared = 0, mismatched = 0, cyc = 0;
    bit tb_self = 0, tb_corrupt = 0, tb_share = 0;
    int tb_w = 1, exp_period = 1, idx = 0, stb_seen = 0, last_stb = 0;
    int sh_div = 0, sh_wsel = 0, sh_n = 1, sh_share = 0;
    logic [7:0] prev_dac = 8'h00, acc = 8'h00;
    int bi = 0;
    logic [7:0] exp_dac[$];
    logic [7:0] exp_resp[$];

    // Analog path stand-in: loopback in self-test, a fixed distortion otherwise.
    function automatic logic [7:0] model(input logic [7:0] d);
        if (tb_self) return d ^ (tb_corrupt ? 8'h01 : 8'h00);
        return d ^ 8'hA5;
    endfunction
    always_comb adc_code = model(dac_code);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        check(0, "watchdog expired", cyc, 150000);
        finish_run();
    end

    // Monitor: compares strobes and reassembled response samples.
    always @(negedge clk) if (rst_n) begin
        if (dac_stb) begin
            if (exp_dac.size() == 0) check(0, "R4 unexpected strobe", dac_code, 0);
            else begin
                logic [7:0] e;
                e = exp_dac.pop_front();
                check(dac_code == e, "R4 dac code", dac_code, e);
            end
            if (idx > 0) check(cyc - last_stb == exp_period, "R3 strobe period", cyc - last_stb, exp_period);
            check(core_sel == (tb_share ? (idx % 2) : 0), "R8 core select", core_sel, tb_share ? (idx % 2) : 0);
            exp_resp.push_back(model(prev_dac));
            prev_dac = dac_code;
            last_stb = cyc;
            idx++;
            stb_seen++;
        end
        if (resp_vld) begin
            check(cyc == last_stb + bi, "R5 beat timing", cyc, last_stb + bi);
            acc = acc | ((resp_dat & 8'((1 << tb_w) - 1)) << (bi * tb_w));
            bi++;
            if (bi == 8 / tb_w) begin
                if (exp_resp.size() == 0) check(0, "R5 unexpected response", acc, 0);
                else begin
                    logic [7:0] e;
                    e = exp_resp.pop_front();
                    check(acc == e, "R5 response sample", acc, e);
                end
                acc = 8'h00;
                bi = 0;
            end
        end
    end

    task automatic load_cfg(input int div, input int wsel, input int n, input int share);
        @(posedge clk); #1;
        cfg_div = 12'(div); cfg_wsel = 2'(wsel); cfg_cnt = 16'(n); cfg_share = share[0];
        cfg_vld = 1;
        @(posedge clk); #1;
        cfg_vld = 0;
        sh_div = div; sh_wsel = wsel; sh_n = n; sh_share = share;
    endtask

    task automatic send(input logic [7:0] v);
        for (int k = 0; k < 8 / tb_w; k++) begin
            stim_vld = 1;
            stim_dat = (v >> (k * tb_w)) & 8'((1 << tb_w) - 1);
            @(posedge clk); #1;
        end
        stim_vld = 0;
    endtask

    task automatic run(input logic [1:0] m, input bit mid);
        int n, base;
        n = sh_n; base = stb_seen;
        tb_w = 1 << sh_wsel; tb_share = sh_share[0]; tb_self = (m == MODE_SELF);
        exp_period = sh_div + 1; idx = 0;
        mode = m; #1;
        check(core_in == 8'h00 && conv_en == 1'b1, "R10 converter route", {conv_en, core_in}, 9'h100);
        start = 1;
        @(posedge clk); #1;
        start = 0;
        check(done == 1'b0, "R6 done cleared by start", done, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(i * 53 + 29 + sh_div * 7);
            if (i > 0) wait (stb_seen == base + i);
            exp_dac.push_back(v);
            send(v);
            if (mid && i == 1) load_cfg(6, 2, 4, 1);
        end
        wait (done);
        repeat (12) @(posedge clk); #1;
        check(stb_seen - base == n, "R6 strobe count", stb_seen - base, n);
        check(done == 1'b1, "R6 done held while idle", done, 1);
        check(exp_dac.size() == 0 && exp_resp.size() == 0, "R5 queues drained",
              exp_dac.size() + exp_resp.size(), 0);
    endtask

    initial begin
        rst_n = 0; mode = MODE_BYPASS; func = 8'h00; cfg_vld = 0; cfg_div = '0;
        cfg_wsel = '0; cfg_cnt = '0; cfg_share = 0; start = 0; stim_vld = 0; stim_dat = '0;
        repeat (5) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        check({done, fail, resp_vld, dac_stb, core_sel} == 5'b0, "R1 reset state",
              {done, fail, resp_vld, dac_stb, core_sel}, 0);

        // R2: bypass routing and ignored start.
        func = 8'h96; #1;
        check(core_in == 8'h96 && conv_en == 1'b0, "R2 bypass route", core_in, 8'h96);
        func = 8'h3C; mode = 2'd3; #1;
        check(core_in == 8'h3C && conv_en == 1'b0, "R2 bypass route code 3", core_in, 8'h3C);
        start = 1; @(posedge clk); #1; start = 0;
        repeat (20) @(posedge clk); #1;
        check(stb_seen == 0 && done == 1'b0, "R2 start ignored in bypass", stb_seen, 0);

        load_cfg(9, 0, 4, 0); run(MODE_TEST, 0);   // R4 R5 one-bit beats
        load_cfg(4, 2, 6, 1); run(MODE_TEST, 0);   // R8 shared cores, 4-bit beats
        load_cfg(1, 3, 6, 0); run(MODE_TEST, 0);   // R3 fastest rate, 8-bit beats
        load_cfg(20, 1, 3, 0); run(MODE_TEST, 1);  // R7 reload during run
        run(MODE_TEST, 0);                         // R7 new image now active

        load_cfg(5, 3, 5, 0); run(MODE_SELF, 0);
        check(fail == 1'b0, "R9 clean loopback", fail, 0);
        tb_corrupt = 1; run(MODE_SELF, 0); tb_corrupt = 0;
        check(fail == 1'b1, "R9 mismatch flagged", fail, 1);
        repeat (10) @(posedge clk); #1;
        check(fail == 1'b1, "R9 flag sticky", fail, 1);
        load_cfg(3, 2, 3, 0); run(MODE_TEST, 0);
        check(fail == 1'b1, "R9 kept through test run", fail, 1);
        run(MODE_SELF, 0);
        check(fail == 1'b0, "R9 cleared by self-test start", fail, 0);

        finish_run();
    end
endmodule